// File: doc/BRIEF.md
# Data-Keyed Power Leakage Marker

This block produces a small, deliberate data-dependent switching signature for detection by differential power analysis. On each operation strobe it forms a single mark bit from two bytes: a data byte whose value the verifier can predict, and a second operand byte. Each data bit is ANDed with the operand bit of the same position, and the eight products are XORed together. The mark bit is registered. A 16-bit load register inverts every one of its bits on the strobes whose mark bit is one, so extra switching activity occurs only on those strobes.

The second operand has two sources. In normal mode it is the round-key byte supplied by the surrounding datapath. In signature mode it is one byte of a stored signature word, selected by a byte index. The byte index advances on every strobe and wraps after the last signature byte, so a run of operations steps through the whole signature. The cryptographic core that supplies the data and key bytes is outside this block; those bytes arrive as plain inputs.

Top module: `wm_input_leak`

## Requirements
- R1: After reset, `leak_bit_o` is 0, `load_o` is 16'h5555 and the signature byte index is 0, so the first signature-mode strobe uses byte 0.
- R2: In normal mode (`sig_mode_i`=0), the clock edge that samples `op_valid_i`=1 sets `leak_bit_o` to the XOR over i=0..7 of `data_i[i] & key_i[i]`. The value is visible right after that edge.
- R3: On an edge with `op_valid_i`=0, `leak_bit_o` keeps its value.
- R4: On a strobe edge, `load_o` inverts all of its bits if the new mark bit is 1, and keeps its value if the new mark bit is 0.
- R5: On an edge with `op_valid_i`=0, `load_o` keeps its value.
- R6: In signature mode (`sig_mode_i`=1), the operand is signature byte k, which is `sig_i[8k+7:8k]`, with k the current byte index. `key_i` has no effect on the result.
- R7: The byte index advances by one on every strobe in either mode. After index SIG_BYTES-1 it wraps to 0.
- R8: `load_o` always holds exactly LOAD_W/2 ones.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| op_valid_i | input | 1 | Operation strobe, one cycle per operation |
| sig_mode_i | input | 1 | 1 selects the stored signature byte as the operand |
| data_i | input | 8 | Known data byte |
| key_i | input | 8 | Round-key byte (normal-mode operand) |
| sig_i | input | SIG_BYTES*8 | Stored signature word, byte 0 in the low bits |
| leak_bit_o | output | 1 | Registered mark bit |
| load_o | output | LOAD_W | Switching load register |

## Verification
The assertions assume that `op_valid_i` and the operand inputs are stable around each rising edge. They also assume that `sig_i` stays constant while signature mode is in use, so that the index alone decides which byte is used. The stimulus drives every input on the falling edge and holds `sig_i` at one fixed value for the whole run. Strobes last one cycle and are separated by idle cycles, so the hold properties are exercised between operations. A run of more strobes than SIG_BYTES drives the byte index across its wrap point.

// File: rtl/wm_pkg.sv
package wm_pkg;
  parameter int unsigned WM_BYTE_W = 8;
  typedef logic [WM_BYTE_W-1:0] wm_byte_t;
endpackage

// File: rtl/wm_operand_sel.sv
module wm_operand_sel
  import wm_pkg::*;
#(
  parameter int unsigned SIG_BYTES = 4,
  localparam int unsigned IDX_W = (SIG_BYTES > 1) ? $clog2(SIG_BYTES) : 1
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic                           step_i,
  input  logic                           sig_mode_i,
  input  wm_byte_t                       key_i,
  input  logic [SIG_BYTES*WM_BYTE_W-1:0] sig_i,
  output wm_byte_t                       operand_o
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(SIG_BYTES - 1);

  logic [IDX_W-1:0] idx_q;
  wm_byte_t         sig_bytes [SIG_BYTES];

  for (genvar g = 0; g < SIG_BYTES; g++) begin : g_split
    assign sig_bytes[g] = sig_i[g*WM_BYTE_W +: WM_BYTE_W];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          idx_q <= '0;
    else if (step_i) begin
      if (idx_q == LAST_IDX) idx_q <= '0;
      else                   idx_q <= idx_q + 1'b1;
    end
  end

  assign operand_o = sig_mode_i ? sig_bytes[idx_q] : key_i;

  // R7
  idx_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    32'(idx_q) < SIG_BYTES);
  // R7
  idx_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && idx_q == LAST_IDX) |=> (idx_q == '0));
endmodule

// File: rtl/wm_pair_fn.sv
module wm_pair_fn
  import wm_pkg::*;
(
  input  wm_byte_t data_i,
  input  wm_byte_t operand_i,
  output logic     bit_o
);
  wm_byte_t prod;

  for (genvar i = 0; i < WM_BYTE_W; i++) begin : g_pair
    assign prod[i] = data_i[i] & operand_i[i];
  end

  assign bit_o = ^prod;
endmodule

// File: rtl/wm_toggle_load.sv
module wm_toggle_load #(
  parameter int unsigned LOAD_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              flip_i,
  output logic [LOAD_W-1:0] q_o
);
  // alternating pattern: every flip moves all bits
  localparam logic [LOAD_W-1:0] INIT = LOAD_W'({(LOAD_W/2){2'b01}});

  logic [LOAD_W-1:0] q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     q <= INIT;
    else if (flip_i) q <= ~q;
  end

  assign q_o = q;
endmodule

// File: rtl/wm_input_leak.sv
module wm_input_leak
  import wm_pkg::*;
#(
  parameter int unsigned SIG_BYTES = 4,
  parameter int unsigned LOAD_W    = 16
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic                           op_valid_i,
  input  logic                           sig_mode_i,
  input  logic [WM_BYTE_W-1:0]           data_i,
  input  logic [WM_BYTE_W-1:0]           key_i,
  input  logic [SIG_BYTES*WM_BYTE_W-1:0] sig_i,
  output logic                           leak_bit_o,
  output logic [LOAD_W-1:0]              load_o
);
  wm_byte_t operand;
  logic     fn_bit;
  logic     leak_q;

  wm_operand_sel #(.SIG_BYTES(SIG_BYTES)) u_sel (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .step_i     (op_valid_i),
    .sig_mode_i (sig_mode_i),
    .key_i      (key_i),
    .sig_i      (sig_i),
    .operand_o  (operand)
  );

  wm_pair_fn u_fn (
    .data_i    (data_i),
    .operand_i (operand),
    .bit_o     (fn_bit)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         leak_q <= 1'b0;
    else if (op_valid_i) leak_q <= fn_bit;
  end

  wm_toggle_load #(.LOAD_W(LOAD_W)) u_load (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .flip_i (op_valid_i & fn_bit),
    .q_o    (load_o)
  );

  assign leak_bit_o = leak_q;

  // R4
  load_flip_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_valid_i |=> (load_o == ($past(load_o) ^ {LOAD_W{leak_bit_o}})));
  // R5
  load_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !op_valid_i |=> $stable(load_o));
  // R3
  bit_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !op_valid_i |=> $stable(leak_bit_o));
  // R8
  load_balance_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(load_o) == LOAD_W/2);
endmodule

// File: tb/wm_input_leak_tb_top.sv
module wm_input_leak_tb_top;
  localparam int unsigned SIG_BYTES = 4;
  localparam int unsigned LOAD_W    = 16;
  localparam logic [31:0] SIG_WORD  = 32'hA53C_0F96;

  typedef struct {
    logic              bit_v;
    logic [LOAD_W-1:0] load_v;
    string             tag;
  } exp_t;

  logic                 clk = 1'b0;
  logic                 rst_n = 1'b0;
  logic                 op_valid = 1'b0;
  logic                 sig_mode = 1'b0;
  logic [7:0]           data = '0;
  logic [7:0]           key = '0;
  logic [SIG_BYTES*8-1:0] sig = SIG_WORD;
  logic                 leak_bit;
  logic [LOAD_W-1:0]    load;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  exp_t              sb_q[$];
  logic [LOAD_W-1:0] exp_load = 16'h5555;
  logic              exp_bit = 1'b0;
  int                exp_idx = 0;

  always #5 clk = ~clk;

  wm_input_leak #(.SIG_BYTES(SIG_BYTES), .LOAD_W(LOAD_W)) dut_i (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .op_valid_i (op_valid),
    .sig_mode_i (sig_mode),
    .data_i     (data),
    .key_i      (key),
    .sig_i      (sig),
    .leak_bit_o (leak_bit),
    .load_o     (load)
  );

  task automatic check(input string tag, input logic [LOAD_W-1:0] act,
                       input logic [LOAD_W-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic do_op(input logic [7:0] d, input logic [7:0] k,
                       input logic mode, input string tag);
    logic [7:0] opnd;
    exp_t e;
    @(negedge clk);
    data = d; key = k; sig_mode = mode; op_valid = 1'b1;
    opnd = mode ? SIG_WORD[exp_idx*8 +: 8] : k;
    exp_bit = ^(d & opnd);
    if (exp_bit) exp_load = ~exp_load;
    exp_idx = (exp_idx == SIG_BYTES-1) ? 0 : exp_idx + 1;
    e.bit_v = exp_bit; e.load_v = exp_load; e.tag = tag;
    sb_q.push_back(e);
    @(negedge clk);
    op_valid = 1'b0;
    data = ~d; key = ~k;
  endtask

  // monitor
  always @(posedge clk) begin
    if (rst_n && op_valid) begin
      #1;
      if (sb_q.size() == 0) begin
        total++; bad++;
        $display("FAIL %s act=unexpected exp=none", "R2");
      end else begin
        exp_t e;
        e = sb_q.pop_front();
        check({e.tag, " bit"}, LOAD_W'(leak_bit), LOAD_W'(e.bit_v));
        check({e.tag, " load"}, load, e.load_v);
        total++;
        if ($countones(load) != LOAD_W/2) begin
          bad++;
          $display("FAIL R8 act=%0d exp=%0d", $countones(load), LOAD_W/2);
        end
      end
    end
  end

  task automatic idle_check(input int n);
    repeat (n) @(negedge clk);
    check("R3 hold bit", LOAD_W'(leak_bit), LOAD_W'(exp_bit));
    check("R5 hold load", load, exp_load);
  endtask

  initial begin
    #200000;
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog act=hung exp=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] lf;
    repeat (3) @(negedge clk);
    check("R1 reset bit", LOAD_W'(leak_bit), '0);
    check("R1 reset load", load, 16'h5555);
    rst_n = 1'b1;
    // R1 R6 R7: first signature op uses byte 0, then steps and wraps
    do_op(8'hFF, 8'h00, 1'b1, "R1 R6 sig byte0");
    do_op(8'h5A, 8'hFF, 1'b1, "R6 sig byte1");
    do_op(8'hC3, 8'h00, 1'b1, "R6 sig byte2");
    do_op(8'hFF, 8'h12, 1'b1, "R6 sig byte3");
    do_op(8'h81, 8'h77, 1'b1, "R7 sig wrap byte0");
    idle_check(3);
    // R6: key ignored in signature mode
    do_op(8'hF0, 8'h00, 1'b1, "R6 key ignored a");
    do_op(8'hF0, 8'hFF, 1'b1, "R6 key ignored b");
    // R2 R4 normal mode patterns
    do_op(8'hFF, 8'h01, 1'b0, "R2 R4 one pair");
    do_op(8'hFF, 8'h03, 1'b0, "R2 R4 two pairs");
    do_op(8'h00, 8'hFF, 1'b0, "R2 zero data");
    do_op(8'hAA, 8'hFF, 1'b0, "R2 four pairs");
    do_op(8'h80, 8'h80, 1'b0, "R2 msb pair");
    idle_check(4);
    lf = 8'h1D;
    for (int i = 0; i < 24; i++) begin
      do_op(lf, {lf[3:0], lf[7:4]} ^ 8'h6B, i[0], "R2 R6 R7 mixed");
      lf = {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
    end
    idle_check(2);
    repeat (3) @(negedge clk);
    check("R2 queue drained", LOAD_W'(sb_q.size()), '0);
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule